// File: doc/BRIEF.md
# Vector Word Carry-Out Execution Unit

This block is a single-issue execution slice for lane-wise word arithmetic on 128-bit vectors. It takes one 32-bit instruction word per accepted request and decodes it into one of three operations on four 32-bit unsigned lanes. The first is a modulo add. The second is a carry-out add that keeps only each lane's carry bit and drops the sum. The third is a subtract carry-out that reports when no borrow occurs. Encodings it does not support are flagged and have no effect.

Both sources come from a 32-entry, 128-bit vector register file inside the block, and the single result goes back into the same file. Software builds a wide add from the modulo add and the carry-out add. That chaining sequence sits outside this block.

A debug port reads any register combinationally. It can also preload a register when no result is being written.

Top module: `vwc_unit`

## Requirements
- R1: The instruction word is decoded with instr_i[31:26] as the primary opcode, which must equal 4. The destination index is instr_i[25:21], source A is instr_i[20:16], source B is instr_i[15:11], and the extended opcode is instr_i[10:0].
- R2: Extended opcode 384 writes, in every lane, 1 when the unsigned 32-bit sum of the A lane and the B lane overflows, and 0 otherwise. The value is zero-extended to 32 bits and the sum itself is not written.
- R3: Extended opcode 128 writes, in every lane, the low 32 bits of the sum of the A lane and the B lane.
- R4: Extended opcode 1408 writes, in every lane, 1 when the A lane is greater than or equal to the B lane as unsigned values, and 0 otherwise.
- R5: Lane 0 occupies bits 127:96 of a register and lane 3 occupies bits 31:0. Each lane is computed only from the same lane of the sources.
- R6: When the primary opcode is not 4, or the extended opcode is none of 128, 384 and 1408, illegal_o is high for exactly the one cycle after acceptance. In that case done_o stays low and no register changes.
- R7: A request is accepted in a cycle where valid_i and ready_o are both high. For a legal request, done_o is high for exactly the next cycle. ready_o is low in that cycle and high again in the cycle after it. The result is visible on the debug port from that cycle on.
- R8: The destination may be the same register as either source or both sources. The result is computed from the source values held before the write.
- R9: After reset every register holds zero, ready_o is high, and done_o and illegal_o are low.
- R10: dbg_data_o always shows the register selected by dbg_addr_i. When dbg_we_i is high at a clock edge, dbg_wdata_i is written to that register. This does not happen in a cycle where done_o is high: the debug write is then dropped for every address.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction request |
| instr_i | input | 32 | Instruction word |
| ready_o | output | 1 | The unit can accept a request this cycle |
| done_o | output | 1 | One-cycle pulse while a legal result is written |
| illegal_o | output | 1 | One-cycle pulse for an unsupported encoding |
| dbg_addr_i | input | 5 | Debug register index |
| dbg_we_i | input | 1 | Debug write strobe |
| dbg_wdata_i | input | 128 | Debug write data |
| dbg_data_o | output | 128 | Contents of the register at dbg_addr_i |

## Verification
The acceptance edge registers either a done or an illegal pulse, so that pulse is due one cycle after the request is taken. The register file is updated at the edge that ends the pulse cycle, which puts the result on the debug read port two cycles after acceptance. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It checks the pulse and the low ready one falling edge after acceptance, checks that both have cleared at the next falling edge, and only then reads the destination register. Debug writes are checked one falling edge after the edge that takes them, including the write that is dropped during a done cycle.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned XO_W    = 11;
  localparam int unsigned PO_W    = 6;
  localparam int unsigned REG_N   = 1 << RIDX_W;

  localparam logic [PO_W-1:0] PO_VEC  = 6'd4;
  localparam logic [XO_W-1:0] XO_ADDM = 11'd128;
  localparam logic [XO_W-1:0] XO_ADDC = 11'd384;
  localparam logic [XO_W-1:0] XO_SUBC = 11'd1408;

  typedef enum logic [1:0] {
    OP_ADDM = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUBC = 2'd2,
    OP_BAD  = 2'd3
  } vop_e;

  typedef struct packed {
    vop_e              op;
    logic [RIDX_W-1:0] vd;
    logic [RIDX_W-1:0] va;
    logic [RIDX_W-1:0] vb;
  } vdec_t;
endpackage

// File: rtl/vwc_decode.sv
module vwc_decode
  import vwc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output vdec_t              dec_o
);
  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;

  assign po = instr_i[INSTR_W-1 -: PO_W];
  assign xo = instr_i[XO_W-1:0];

  always_comb begin
    dec_o.vd = instr_i[INSTR_W-PO_W-1 -: RIDX_W];
    dec_o.va = instr_i[INSTR_W-PO_W-RIDX_W-1 -: RIDX_W];
    dec_o.vb = instr_i[INSTR_W-PO_W-2*RIDX_W-1 -: RIDX_W];
    dec_o.op = OP_BAD;
    if (po == PO_VEC) begin
      unique case (xo)
        XO_ADDM: dec_o.op = OP_ADDM;
        XO_ADDC: dec_o.op = OP_ADDC;
        XO_SUBC: dec_o.op = OP_SUBC;
        default: dec_o.op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/vwc_lane.sv
module vwc_lane
  import vwc_pkg::*;
#(
  parameter int unsigned LANE_W = 32
) (
  input  vop_e              op_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] res_o
);
  logic [LANE_W:0] sum;
  logic            no_borrow;

  assign sum       = {1'b0, a_i} + {1'b0, b_i};
  assign no_borrow = (a_i >= b_i);

  always_comb begin
    unique case (op_i)
      OP_ADDM: res_o = sum[LANE_W-1:0];
      OP_ADDC: res_o = {{(LANE_W-1){1'b0}}, sum[LANE_W]};
      OP_SUBC: res_o = {{(LANE_W-1){1'b0}}, no_borrow};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/vwc_regfile.sv
module vwc_regfile #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ra_a_i,
  input  logic [AW-1:0]    ra_b_i,
  input  logic [AW-1:0]    ra_d_i,
  output logic [VEC_W-1:0] rd_a_o,
  output logic [VEC_W-1:0] rd_b_o,
  output logic [VEC_W-1:0] rd_d_o,
  input  logic             we_i,
  input  logic [AW-1:0]    wa_i,
  input  logic [VEC_W-1:0] wd_i
);
  logic [VEC_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = mem_q[ra_a_i];
  assign rd_b_o = mem_q[ra_b_i];
  assign rd_d_o = mem_q[ra_d_i];
endmodule

// File: rtl/vwc_unit.sv
module vwc_unit
  import vwc_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               illegal_o,
  input  logic [RIDX_W-1:0]  dbg_addr_i,
  input  logic               dbg_we_i,
  input  logic [VEC_W-1:0]   dbg_wdata_i,
  output logic [VEC_W-1:0]   dbg_data_o
);
  vdec_t             dec;
  logic [VEC_W-1:0]  src_a, src_b, res;
  logic              accept;
  logic              busy_q, done_q, ill_q;
  vop_e              op_q;
  logic [RIDX_W-1:0] wa_q;
  logic [VEC_W-1:0]  wd_q;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_wa;
  logic [VEC_W-1:0]  rf_wd;

  vwc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  vwc_regfile #(.VEC_W(VEC_W), .DEPTH(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (dec.va),
    .ra_b_i (dec.vb),
    .ra_d_i (dbg_addr_i),
    .rd_a_o (src_a),
    .rd_b_o (src_b),
    .rd_d_o (dbg_data_o),
    .we_i   (rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  // lane 0 is the most-significant word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vwc_lane #(.LANE_W(LANE_W)) u_lane (
      .op_i  (dec.op),
      .a_i   (src_a[VEC_W-1-g*LANE_W -: LANE_W]),
      .b_i   (src_b[VEC_W-1-g*LANE_W -: LANE_W]),
      .res_o (res[VEC_W-1-g*LANE_W -: LANE_W])
    );
  end

  assign ready_o = ~busy_q;
  assign accept  = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      op_q   <= OP_BAD;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      busy_q <= accept;
      done_q <= accept & (dec.op != OP_BAD);
      ill_q  <= accept & (dec.op == OP_BAD);
      if (accept) begin
        op_q <= dec.op;
        wa_q <= dec.vd;
        wd_q <= res;
      end
    end
  end

  // result write has priority over the debug write
  assign rf_we = done_q | dbg_we_i;
  assign rf_wa = done_q ? wa_q : dbg_addr_i;
  assign rf_wd = done_q ? wd_q : dbg_wdata_i;

  assign done_o    = done_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/vwc_unit_chk.sv
module vwc_unit_chk
  import vwc_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             illegal_o,
  input vop_e             op_q,
  input logic [VEC_W-1:0] wd_q
);
  function automatic logic [VEC_W-1:0] lsb_mask();
    logic [VEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) m[i*LANE_W] = 1'b1;
    return m;
  endfunction

  localparam logic [VEC_W-1:0] LSB_MASK = lsb_mask();

  a_r7_pulse_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (done_o || illegal_o));

  a_r7_pulse_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || illegal_o) |-> $past(valid_i && ready_o));

  a_r7_busy_during_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || illegal_o) |-> !ready_o);

  a_r6_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_carry_is_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_ADDC) |-> ((wd_q & ~LSB_MASK) == '0));

  a_r4_borrow_is_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_SUBC) |-> ((wd_q & ~LSB_MASK) == '0));
endmodule

bind vwc_unit vwc_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .ready_o   (ready_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .op_q      (op_q),
  .wd_q      (wd_q)
);

// File: tb/sim_vwc_unit.sv
`timescale 1ns/1ps
module sim_vwc_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic         ready_o, done_o, illegal_o;
  logic [4:0]   dbg_addr_i = '0;
  logic         dbg_we_i = 1'b0;
  logic [127:0] dbg_wdata_i = '0;
  logic [127:0] dbg_data_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  vwc_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .ready_o(ready_o), .done_o(done_o), .illegal_o(illegal_o),
    .dbg_addr_i(dbg_addr_i), .dbg_we_i(dbg_we_i),
    .dbg_wdata_i(dbg_wdata_i), .dbg_data_o(dbg_data_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] po, input logic [4:0] vd,
                                      input logic [4:0] va, input logic [4:0] vb,
                                      input logic [10:0] xo);
    return {po, vd, va, vb, xo};
  endfunction

  task automatic dbg_wr(input logic [4:0] a, input logic [127:0] d);
    @(negedge clk_i);
    dbg_addr_i = a; dbg_we_i = 1'b1; dbg_wdata_i = d;
    @(negedge clk_i);
    dbg_we_i = 1'b0;
  endtask

  task automatic dbg_rd(input string tag, input logic [4:0] a, input logic [127:0] exp);
    dbg_addr_i = a;
    #0.1;
    chk(tag, dbg_data_o, exp);
  endtask

  // issue, check pulse one falling edge after acceptance, then release
  task automatic issue(input string tag, input logic [31:0] ins, input logic legal);
    @(negedge clk_i);
    chk({tag, " ready before"}, {127'd0, ready_o}, 128'd1);
    valid_i = 1'b1; instr_i = ins;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({tag, " done"}, {127'd0, done_o}, {127'd0, legal});
    chk({tag, " illegal"}, {127'd0, illegal_o}, {127'd0, ~legal});
    chk({tag, " ready low"}, {127'd0, ready_o}, 128'd0);
    @(negedge clk_i);
    chk({tag, " pulse end"}, {126'd0, done_o, illegal_o}, 128'd0);
    chk({tag, " ready back"}, {127'd0, ready_o}, 128'd1);
  endtask

  localparam logic [127:0] SA = {32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h00000000};
  localparam logic [127:0] SB = {32'h00000001, 32'h80000000, 32'h80000000, 32'h00000000};

  task automatic t_reset();
    chk("R9 ready", {127'd0, ready_o}, 128'd1);
    chk("R9 pulses", {126'd0, done_o, illegal_o}, 128'd0);
    dbg_rd("R9 reg0", 5'd0, '0);
    dbg_rd("R9 reg31", 5'd31, '0);
  endtask

  task automatic t_dbg();
    dbg_wr(5'd1, SA);
    dbg_wr(5'd2, SB);
    dbg_rd("R10 readback r1", 5'd1, SA);
    dbg_rd("R10 readback r2", 5'd2, SB);
  endtask

  task automatic t_addc();
    issue("R2 addc", enc(6'd4, 5'd3, 5'd1, 5'd2, 11'd384), 1'b1);
    dbg_rd("R2 R5 carry lanes", 5'd3, {32'd1, 32'd0, 32'd1, 32'd0});
  endtask

  task automatic t_addm();
    issue("R3 addm", enc(6'd4, 5'd4, 5'd1, 5'd2, 11'd128), 1'b1);
    dbg_rd("R3 modulo sum", 5'd4, {32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h00000000});
  endtask

  task automatic t_subc();
    dbg_wr(5'd5, {32'h12345678, 32'h00000005, 32'h00000009, 32'h00000000});
    dbg_wr(5'd6, {32'h12345678, 32'h00000006, 32'h00000008, 32'hFFFFFFFF});
    issue("R4 subc", enc(6'd4, 5'd7, 5'd5, 5'd6, 11'd1408), 1'b1);
    dbg_rd("R4 no-borrow lanes", 5'd7, {32'd1, 32'd0, 32'd1, 32'd0});
  endtask

  task automatic t_lane_order();
    dbg_wr(5'd8, {32'h00000010, 32'h00000020, 32'h00000030, 32'hF0000000});
    dbg_wr(5'd9, {32'h00000001, 32'h00000002, 32'h00000003, 32'h20000000});
    issue("R5 addc", enc(6'd4, 5'd10, 5'd8, 5'd9, 11'd384), 1'b1);
    dbg_rd("R5 only lane3 carries", 5'd10, 128'd1);
    issue("R5 addm", enc(6'd4, 5'd10, 5'd8, 5'd9, 11'd128), 1'b1);
    dbg_rd("R5 no cross-lane carry", 5'd10,
           {32'h00000011, 32'h00000022, 32'h00000033, 32'h10000000});
  endtask

  task automatic t_illegal();
    logic [127:0] pre = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    dbg_wr(5'd11, pre);
    issue("R6 bad primary", enc(6'd5, 5'd11, 5'd1, 5'd2, 11'd384), 1'b0);
    dbg_rd("R6 dest kept (primary)", 5'd11, pre);
    issue("R6 bad xo", enc(6'd4, 5'd11, 5'd1, 5'd2, 11'd385), 1'b0);
    dbg_rd("R6 dest kept (xo)", 5'd11, pre);
  endtask

  task automatic t_alias();
    logic [127:0] a = {32'hFFFFFFFE, 32'h00000001, 32'h40000000, 32'h00000100};
    logic [127:0] b = {32'h00000003, 32'h00000002, 32'hC0000000, 32'h00000001};
    dbg_wr(5'd12, a);
    dbg_wr(5'd13, b);
    issue("R8 vd=va", enc(6'd4, 5'd12, 5'd12, 5'd13, 11'd128), 1'b1);
    dbg_rd("R8 alias sum", 5'd12, {32'h00000001, 32'h00000003, 32'h00000000, 32'h00000101});
    dbg_wr(5'd14, {32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000});
    issue("R8 all same", enc(6'd4, 5'd14, 5'd14, 5'd14, 11'd384), 1'b1);
    dbg_rd("R8 alias carry", 5'd14, {32'd1, 32'd0, 32'd1, 32'd0});
  endtask

  task automatic t_fields();
    logic [127:0] a = {32'd7, 32'd7, 32'd1, 32'd100};
    logic [127:0] b = {32'd3, 32'd8, 32'd1, 32'd200};
    dbg_wr(5'd17, a);
    dbg_wr(5'd9, b);
    issue("R1 fields", enc(6'd4, 5'd30, 5'd17, 5'd9, 11'd1408), 1'b1);
    dbg_rd("R1 dest r30", 5'd30, {32'd1, 32'd0, 32'd1, 32'd0});
    dbg_rd("R1 src a kept", 5'd17, a);
    dbg_rd("R1 src b kept", 5'd9, b);
  endtask

  task automatic t_dbg_collide();
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = enc(6'd4, 5'd20, 5'd1, 5'd2, 11'd384);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R10 done in collide", {127'd0, done_o}, 128'd1);
    dbg_addr_i = 5'd21; dbg_we_i = 1'b1; dbg_wdata_i = {4{32'h55AA55AA}};
    @(negedge clk_i);
    dbg_we_i = 1'b0;
    dbg_rd("R10 dropped debug write", 5'd21, '0);
    dbg_rd("R10 result kept", 5'd20, {32'd1, 32'd0, 32'd1, 32'd0});
  endtask

  initial begin
    #1;
    t_reset();
    #6 rst_ni = 1'b1;
    t_dbg();
    t_addc();
    t_addm();
    t_subc();
    t_lane_order();
    t_illegal();
    t_alias();
    t_fields();
    t_dbg_collide();
    #8;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule